// File: doc/BRIEF.md
# Line Interface Loopback Selector

This block steers the digital clock and rail signals of one line interface port between normal service and the port's test loopbacks. On the line side it picks what the transmitter sends: the encoded system data, an alarm indication signal (AIS) pattern, or the raw received rails turned straight back toward the far end. On the system side it picks what the receive outputs carry: the recovered clock with the decoder outputs, or the system's own transmit clock and rails looped back locally. It also raises a control line that tells the analog front end to close its internal analog loop.

Software or pins supply a 2-bit loopback code, an AIS choice bit and an extra line-loopback enable. All three are captured in a register on the control clock, and only the registered copy steers the multiplexers. A mode change therefore lands on a clock edge and never part-way through a cycle. The line coder, the analog front end and clock recovery are outside this block.

Top module: `lb_port_router`

## Requirements
- R1: After a synchronous active-low reset, the port is in normal mode. `alb_en` is 0. The line outputs carry `tx_clk` with `enc_pos`/`enc_neg`. The system receive outputs carry `rx_clk` with `dec_d0`/`dec_d1`.
- R2: `lb_code` is decoded as follows: 0 (binary 00) selects no loopback, 1 (01) selects analog, 2 (10) selects line and 3 (11) selects diagnostic.
- R3: In analog mode `alb_en` is 1, and both the line outputs and the system receive outputs stay as in normal mode. `alb_en` is 0 in every other mode.
- R4: In line loopback the line outputs equal `rx_clk`, `rx_pos` and `rx_neg` taken from before the decoder, bit for bit. The system transmit and encoder inputs have no effect on the line outputs. The system receive outputs still carry `rx_clk` and the decoder outputs.
- R5: In diagnostic mode the system receive outputs equal `tx_clk`, `tx_d0` and `tx_d1`.
- R6: In diagnostic mode with line loopback off, the line outputs carry `tx_clk` together with `enc_pos`/`enc_neg` when `ais_on` is 0. When `ais_on` is 1 they carry `tx_clk` together with `ais_pos`/`ais_neg`.
- R7: With `lb_code` = 3 and `llb_on` = 1, diagnostic and line loopback run together. The line outputs carry the raw received signals and the system receive outputs carry the transmit inputs.
- R8: `llb_on` = 1 turns on line loopback under any code. Under code 0 this gives line loopback with normal system receive outputs.
- R9: Changes on `lb_code`, `ais_on` and `llb_on` do not affect the outputs until the next rising edge of `clk`. After that edge the new mode applies.
- R10: `ais_on` has no effect on any output unless the mode is diagnostic with line loopback off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock that captures the mode selects |
| rst_n | input | 1 | Synchronous active-low reset |
| lb_code | input | 2 | Loopback code: 0 none, 1 analog, 2 line, 3 diagnostic |
| ais_on | input | 1 | Send AIS on the line during diagnostic loopback |
| llb_on | input | 1 | Extra line-loopback enable, allows the combined mode |
| rx_clk | input | 1 | Recovered receive clock |
| rx_pos | input | RAIL_W | Raw positive receive rail, before the decoder |
| rx_neg | input | RAIL_W | Raw negative receive rail, before the decoder |
| dec_d0 | input | RAIL_W | Decoder data output |
| dec_d1 | input | RAIL_W | Decoder violation/second rail output |
| tx_clk | input | 1 | System transmit clock |
| tx_d0 | input | RAIL_W | System transmit data/positive rail |
| tx_d1 | input | RAIL_W | System transmit negative rail |
| enc_pos | input | RAIL_W | Encoder positive rail output |
| enc_neg | input | RAIL_W | Encoder negative rail output |
| ais_pos | input | RAIL_W | AIS generator positive rail |
| ais_neg | input | RAIL_W | AIS generator negative rail |
| line_clk | output | 1 | Line-side transmit clock |
| line_pos | output | RAIL_W | Line-side positive transmit rail |
| line_neg | output | RAIL_W | Line-side negative transmit rail |
| sys_clk | output | 1 | System-side receive clock |
| sys_d0 | output | RAIL_W | System-side receive data/positive rail |
| sys_d1 | output | RAIL_W | System-side receive second rail |
| alb_en | output | 1 | Analog loopback request to the front end |

## Verification
In every mode, each signal source (raw receive rails, decoder, system transmit, encoder, AIS) is driven with its own random value, changed 16 times. An output that copies the wrong source, for example the decoded rails instead of the raw ones in line loopback, therefore shows up as a mismatch. Each mode is run with `ais_on` both low and high. This separates the AIS route from the encoder route and shows that the AIS bit does nothing outside diagnostic-only mode. A separate pattern changes the selects between clock edges and samples before and after the next edge, which separates registered switching from direct decoding.

// File: rtl/lb_port_pkg.sv
// Package: shared loopback code and decoded control for the port router.
// Assumes a 2-bit code; the decode is used by the mode register only.
package lb_port_pkg;

    typedef enum logic [1:0] {
        LB_NONE   = 2'd0,
        LB_ANALOG = 2'd1,
        LB_LINE   = 2'd2,
        LB_DIAG   = 2'd3
    } lb_code_e;

    typedef struct packed {
        logic alb;   // analog loop requested
        logic llb;   // line loop active
        logic dlb;   // diagnostic loop active
        logic ais;   // AIS replaces encoder output on the line
    } lb_ctl_t;

    localparam lb_ctl_t LB_CTL_RESET = '{alb: 1'b0, llb: 1'b0, dlb: 1'b0, ais: 1'b0};

    // Turns the raw selects into one-hot-ish path controls.
    function automatic lb_ctl_t lb_decode(input logic [1:0] code,
                                          input logic ais_req,
                                          input logic llb_req);
        lb_ctl_t c;
        c.alb = (code == LB_ANALOG);
        c.llb = (code == LB_LINE) || llb_req;
        c.dlb = (code == LB_DIAG);
        c.ais = c.dlb && !c.llb && ais_req;
        return c;
    endfunction

endpackage

// File: rtl/lb_mode_reg.sv
// Module: lb_mode_reg
// Captures the loopback selects on clk and holds the decoded controls.
// Assumes the selects are synchronous to clk; outputs change only on an edge.
module lb_mode_reg
    import lb_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  code_in,
    input  logic        ais_req,
    input  logic        llb_req,
    output lb_ctl_t     ctl
);

    // Registers the decoded mode so muxes switch only at a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl <= LB_CTL_RESET;
        else        ctl <= lb_decode(code_in, ais_req, llb_req);
    end

    // R9: the held mode reflects the selects seen at the previous edge
    a_r9_registered_code: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ctl.dlb == ($past(code_in) == LB_DIAG)) &&
                          (ctl.alb == ($past(code_in) == LB_ANALOG)));

    // R3: analog request never coexists with diagnostic loop
    a_r3_alb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.alb |-> !ctl.dlb);

endmodule

// File: rtl/lb_line_mux.sv
// Module: lb_line_mux
// Chooses the line-side transmit clock and rails: raw receive (line loop),
// AIS pattern or encoder output. AIS and encoder both ride on tx_clk.
module lb_line_mux #(
    parameter int RAIL_W = 1
) (
    input  logic              sel_raw,
    input  logic              sel_ais,
    input  logic              rx_clk,
    input  logic [RAIL_W-1:0] rx_pos,
    input  logic [RAIL_W-1:0] rx_neg,
    input  logic              tx_clk,
    input  logic [RAIL_W-1:0] enc_pos,
    input  logic [RAIL_W-1:0] enc_neg,
    input  logic [RAIL_W-1:0] ais_pos,
    input  logic [RAIL_W-1:0] ais_neg,
    output logic              o_clk,
    output logic [RAIL_W-1:0] o_pos,
    output logic [RAIL_W-1:0] o_neg
);

    // Priority: line loop first, then AIS, else encoded transmit data.
    always_comb begin
        if (sel_raw) begin
            o_clk = rx_clk;
            o_pos = rx_pos;
            o_neg = rx_neg;
        end else if (sel_ais) begin
            o_clk = tx_clk;
            o_pos = ais_pos;
            o_neg = ais_neg;
        end else begin
            o_clk = tx_clk;
            o_pos = enc_pos;
            o_neg = enc_neg;
        end
    end

endmodule

// File: rtl/lb_sys_mux.sv
// Module: lb_sys_mux
// Chooses the system-side receive clock and rails: transmit inputs looped
// locally (diagnostic) or recovered clock with decoder outputs.
module lb_sys_mux #(
    parameter int RAIL_W = 1
) (
    input  logic              sel_local,
    input  logic              rx_clk,
    input  logic [RAIL_W-1:0] dec_d0,
    input  logic [RAIL_W-1:0] dec_d1,
    input  logic              tx_clk,
    input  logic [RAIL_W-1:0] tx_d0,
    input  logic [RAIL_W-1:0] tx_d1,
    output logic              o_clk,
    output logic [RAIL_W-1:0] o_d0,
    output logic [RAIL_W-1:0] o_d1
);

    // Local loop feeds transmit straight back; otherwise pass the receiver.
    always_comb begin
        o_clk = sel_local ? tx_clk : rx_clk;
        o_d0  = sel_local ? tx_d0  : dec_d0;
        o_d1  = sel_local ? tx_d1  : dec_d1;
    end

endmodule

// File: rtl/lb_port_router.sv
// Module: lb_port_router (top)
// Routes one port's clock and rails among normal, analog, line, diagnostic
// and combined loopbacks. Mode selects are registered on clk; data paths are
// combinational muxes driven by the held mode. Assumes the codec, analog
// front end and clock recovery sit outside.
module lb_port_router
    import lb_port_pkg::*;
#(
    parameter int RAIL_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lb_code,
    input  logic              ais_on,
    input  logic              llb_on,
    input  logic              rx_clk,
    input  logic [RAIL_W-1:0] rx_pos,
    input  logic [RAIL_W-1:0] rx_neg,
    input  logic [RAIL_W-1:0] dec_d0,
    input  logic [RAIL_W-1:0] dec_d1,
    input  logic              tx_clk,
    input  logic [RAIL_W-1:0] tx_d0,
    input  logic [RAIL_W-1:0] tx_d1,
    input  logic [RAIL_W-1:0] enc_pos,
    input  logic [RAIL_W-1:0] enc_neg,
    input  logic [RAIL_W-1:0] ais_pos,
    input  logic [RAIL_W-1:0] ais_neg,
    output logic              line_clk,
    output logic [RAIL_W-1:0] line_pos,
    output logic [RAIL_W-1:0] line_neg,
    output logic              sys_clk,
    output logic [RAIL_W-1:0] sys_d0,
    output logic [RAIL_W-1:0] sys_d1,
    output logic              alb_en
);

    lb_ctl_t ctl;

    lb_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_in (lb_code),
        .ais_req (ais_on),
        .llb_req (llb_on),
        .ctl     (ctl)
    );

    lb_line_mux #(.RAIL_W(RAIL_W)) u_line (
        .sel_raw (ctl.llb),
        .sel_ais (ctl.ais),
        .rx_clk  (rx_clk),
        .rx_pos  (rx_pos),
        .rx_neg  (rx_neg),
        .tx_clk  (tx_clk),
        .enc_pos (enc_pos),
        .enc_neg (enc_neg),
        .ais_pos (ais_pos),
        .ais_neg (ais_neg),
        .o_clk   (line_clk),
        .o_pos   (line_pos),
        .o_neg   (line_neg)
    );

    lb_sys_mux #(.RAIL_W(RAIL_W)) u_sys (
        .sel_local (ctl.dlb),
        .rx_clk    (rx_clk),
        .dec_d0    (dec_d0),
        .dec_d1    (dec_d1),
        .tx_clk    (tx_clk),
        .tx_d0     (tx_d0),
        .tx_d1     (tx_d1),
        .o_clk     (sys_clk),
        .o_d0      (sys_d0),
        .o_d1      (sys_d1)
    );

    // Drives the analog loop request from the held mode.
    assign alb_en = ctl.alb;

    // R4: line loop copies raw rails, not decoder output
    a_r4_raw_line: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(lb_code) == LB_LINE)) |->
            (line_pos == rx_pos) && (line_neg == rx_neg) && (sys_d0 == dec_d0));

    // R5: diagnostic loop returns transmit rails to the system side
    a_r5_diag_local: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(lb_code) == LB_DIAG)) |->
            (sys_d0 == tx_d0) && (sys_d1 == tx_d1));

    // R7: combined mode loops both directions
    a_r7_combined: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(lb_code) == LB_DIAG) && $past(llb_on)) |->
            (line_pos == rx_pos) && (sys_d1 == tx_d1));

    // R3: analog request leaves the line output on the encoder
    a_r3_analog_line: assert property (@(posedge clk) disable iff (!rst_n)
        (alb_en && !ctl.llb) |-> (line_pos == enc_pos) && (line_neg == enc_neg));

endmodule

// File: tb/lb_port_router_test.sv
`timescale 1ns/1ps
module lb_port_router_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] lb_code = 2'd0;
    logic ais_on = 1'b0, llb_on = 1'b0;
    logic rx_clk = 0, rx_pos = 0, rx_neg = 0, dec_d0 = 0, dec_d1 = 0;
    logic tx_clk = 0, tx_d0 = 0, tx_d1 = 0, enc_pos = 0, enc_neg = 0;
    logic ais_pos = 0, ais_neg = 0;
    logic line_clk, line_pos, line_neg, sys_clk, sys_d0, sys_d1, alb_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lb_port_router #(.RAIL_W(1)) uut (
        .clk(clk), .rst_n(rst_n), .lb_code(lb_code), .ais_on(ais_on), .llb_on(llb_on),
        .rx_clk(rx_clk), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .dec_d0(dec_d0), .dec_d1(dec_d1),
        .tx_clk(tx_clk), .tx_d0(tx_d0), .tx_d1(tx_d1),
        .enc_pos(enc_pos), .enc_neg(enc_neg), .ais_pos(ais_pos), .ais_neg(ais_neg),
        .line_clk(line_clk), .line_pos(line_pos), .line_neg(line_neg),
        .sys_clk(sys_clk), .sys_d0(sys_d0), .sys_d1(sys_d1), .alb_en(alb_en)
    );

    // Expected outputs {line clk,pos,neg, sys clk,d0,d1, alb} for a held mode.
    function automatic logic [6:0] model(input logic [1:0] code, input logic ais,
                                         input logic llb);
        logic l_on, d_on;
        logic [2:0] ln, sy;
        l_on = (code == 2'd2) || llb;
        d_on = (code == 2'd3);
        if (l_on)              ln = {rx_clk, rx_pos, rx_neg};
        else if (d_on && ais)  ln = {tx_clk, ais_pos, ais_neg};
        else                   ln = {tx_clk, enc_pos, enc_neg};
        sy = d_on ? {tx_clk, tx_d0, tx_d1} : {rx_clk, dec_d0, dec_d1};
        return {ln, sy, code == 2'd1};
    endfunction

    task automatic check(input string req, input logic [6:0] exp);
        logic [6:0] act;
        act = {line_clk, line_pos, line_neg, sys_clk, sys_d0, sys_d1, alb_en};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic scramble();
        logic [15:0] r;
        r = 16'($urandom);
        {rx_clk, rx_pos, rx_neg, dec_d0, dec_d1, tx_clk, tx_d0, tx_d1} = r[7:0];
        {enc_pos, enc_neg, ais_pos, ais_neg} = r[11:8];
    endtask

    // Apply a mode, let it register, then sweep source patterns.
    task automatic run_mode(input string req, input logic [1:0] code,
                            input logic ais, input logic llb);
        @(negedge clk);
        lb_code = code; ais_on = ais; llb_on = llb;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            scramble();
            #1;
            check(req, model(code, ais, llb));
            @(negedge clk);
        end
    endtask

    // R1: state immediately after reset.
    task automatic t_reset();
        lb_code = 2'd3; ais_on = 1; llb_on = 1;
        rst_n = 0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            scramble(); #1;
            check("R1 reset normal", model(2'd0, 1'b0, 1'b0));
            @(negedge clk);
        end
        lb_code = 2'd0; ais_on = 0; llb_on = 0;
        rst_n = 1;
        @(negedge clk);
    endtask

    // R9: selects change between edges; outputs wait for the edge.
    task automatic t_registered();
        @(negedge clk);
        lb_code = 2'd0; ais_on = 0; llb_on = 0;
        @(negedge clk);
        scramble();
        lb_code = 2'd3; ais_on = 1;
        #1;
        check("R9 before edge", model(2'd0, 1'b0, 1'b0));
        @(negedge clk); #1;
        check("R9 after edge", model(2'd3, 1'b1, 1'b0));
        llb_on = 1;
        #0.5;
        check("R9 llb before edge", model(2'd3, 1'b1, 1'b0));
        @(negedge clk); #1;
        check("R9 llb after edge", model(2'd3, 1'b1, 1'b1));
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        run_mode("R2 R1 normal", 2'd0, 1'b0, 1'b0);
        run_mode("R10 normal ais ignored", 2'd0, 1'b1, 1'b0);
        run_mode("R3 analog", 2'd1, 1'b0, 1'b0);
        run_mode("R10 analog ais ignored", 2'd1, 1'b1, 1'b0);
        run_mode("R4 line loop", 2'd2, 1'b0, 1'b0);
        run_mode("R10 line ais ignored", 2'd2, 1'b1, 1'b0);
        run_mode("R5 R6 diag encoder", 2'd3, 1'b0, 1'b0);
        run_mode("R6 diag ais", 2'd3, 1'b1, 1'b0);
        run_mode("R7 combined", 2'd3, 1'b0, 1'b1);
        run_mode("R10 combined ais ignored", 2'd3, 1'b1, 1'b1);
        run_mode("R8 llb under none", 2'd0, 1'b0, 1'b1);
        run_mode("R8 llb under analog", 2'd1, 1'b1, 1'b1);
        t_registered();
        t_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule